// File: doc/BRIEF.md
# USB Device Interrupt Status Aggregator

This block collects the interrupt events of a USB device controller into one 32-bit status word and drives a single interrupt line to the host processor. Each endpoint buffer has a receive bit and a transmit bit. Five bus-state conditions each have their own bit: bus reset, suspend, resume, start-of-frame and pseudo start-of-frame. One more bit summarises the DMA engine.

Events arrive as single-cycle pulses and set their bits, which then stay set. Software reads the word to find the cause of an interrupt and clears bits by writing ones to them. Bits written with zero keep their value.

The DMA bit does not latch an event directly. It mirrors a separate DMA reason register, which is cleared in the same write-one-to-clear way. To clear a DMA interrupt fully, software first clears the cause in the reason register and then clears the DMA status bit.

Top module: `usb_irq_agg`

## Requirements
- R1: After synchronous reset, every status bit, every reason bit, `rd_data` and `irq` read zero.
- R2: A pulse on `bus_evt[k]` sets status bit k at the next clock edge, and the bit stays set without further pulses. The mapping is k=0 bus reset, k=1 suspend, k=2 resume, k=3 start-of-frame, k=4 pseudo start-of-frame.
- R3: `irq` is 1 in exactly those cycles in which the status word is non-zero. It changes at the same edge as the status bits.
- R4: A pulse on `ep_rx_evt[n]` sets status bit 8+2n, and a pulse on `ep_tx_evt[n]` sets status bit 9+2n.
- R5: A write with `wr_sel`=0 clears each status bit whose `wr_data` bit is 1 and leaves each bit written with 0 unchanged.
- R6: Status bits 6, 7 and all bits from 8+2·NUM_EP upward always read zero, whatever is written.
- R7: If an event and a clear of the same status bit fall in one cycle, the bit is 1 after that edge.
- R8: A pulse on `dma_evt[j]` sets reason bit j. A write with `wr_sel`=1 clears the reason bits written with 1, and a set in the same cycle wins. The reason register reads with `rd_sel`=1, zero-extended.
- R9: Status bit 5 (DMA) becomes 1 one edge after any reason bit is 1. While any reason bit is still set, writing 1 to bit 5 leaves it at 1.
- R10: Once all reason bits are cleared, writing 1 to bit 5 clears it, and `irq` falls if no other status bit is set.
- R11: `rd_data` shows, one edge after `rd_sel` is applied, the selected register as it was before that edge. Reading changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_evt | input | 5 | Bus-state event pulses |
| ep_rx_evt | input | NUM_EP | Per-endpoint receive event pulses |
| ep_tx_evt | input | NUM_EP | Per-endpoint transmit event pulses |
| dma_evt | input | N_RSN | DMA interrupt-cause pulses |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 status, 1 DMA reason |
| wr_data | input | 32 | Write-one-to-clear mask |
| rd_sel | input | 1 | Read target: 0 status, 1 DMA reason |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Interrupt line, high while any status bit is set |

## Verification
The hardest cases to reach involve the DMA summary bit, because it depends on a second register one edge removed. The bench first lets a cause pulse reach the reason register and then the status bit. It then clears the status bit while a cause is still pending and checks that the bit holds. Next it clears the cause, re-clears bit 5 and checks that `irq` falls. Set-versus-clear collisions are built by driving an event pulse and a clearing write in the same cycle, for both the status register and the reason register.

// File: rtl/usb_irq_agg_pkg.sv
package usb_irq_agg_pkg;

  localparam int STAT_W    = 32;
  localparam int BUS_EVT_N = 5;
  localparam int DMA_POS   = 5;
  localparam int EP_BASE   = 8;
  localparam int MAX_EP    = (STAT_W - EP_BASE) / 2;

  // Status bit positions of the bus-state events; the bench decodes these.
  localparam int POS_BUS_RST = 0;
  localparam int POS_SUSPEND = 1;
  localparam int POS_RESUME  = 2;
  localparam int POS_SOF     = 3;
  localparam int POS_PSOF    = 4;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_REASON = 1'b1
  } reg_sel_e;

  function automatic int ep_rx_pos(input int n);
    return EP_BASE + 2 * n;
  endfunction

  function automatic int ep_tx_pos(input int n);
    return EP_BASE + 2 * n + 1;
  endfunction

  // Bits of the status word that hold real state.
  function automatic logic [STAT_W-1:0] impl_mask(input int n_ep);
    logic [STAT_W-1:0] m;
    m = '0;
    for (int i = 0; i < BUS_EVT_N; i++) m[i] = 1'b1;
    m[DMA_POS] = 1'b1;
    for (int n = 0; n < MAX_EP; n++) begin
      if (n < n_ep) begin
        m[EP_BASE + 2 * n]     = 1'b1;
        m[EP_BASE + 2 * n + 1] = 1'b1;
      end
    end
    return m;
  endfunction

endpackage

// File: rtl/usb_irq_w1c_bank.sv
module usb_irq_w1c_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o,
  output logic         any_o
);

  logic [W-1:0] q_r;
  logic [W-1:0] q_nx;
  logic         any_r;

  // Per-bit sticky latch: set has priority over clear.
  genvar b;
  generate
    for (b = 0; b < W; b++) begin : g_bit
      always_comb begin
        if (set_i[b])      q_nx[b] = 1'b1;
        else if (clr_i[b]) q_nx[b] = 1'b0;
        else               q_nx[b] = q_r[b];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      q_r   <= '0;
      any_r <= 1'b0;
    end else begin
      q_r   <= q_nx;
      any_r <= |q_nx;
    end
  end

  assign q_o   = q_r;
  assign any_o = any_r;

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)));

  // R5
  clr_takes_chk: assert property (@(posedge clk) disable iff (rst)
    ((clr_i & ~set_i) != '0) |=> ((q_o & $past(clr_i & ~set_i)) == '0));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (set_i == '0 && clr_i == '0) |=> $stable(q_o));

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    $past(rst) |-> (q_o == '0 && !any_o));

endmodule

// File: rtl/usb_irq_src_map.sv
module usb_irq_src_map
  import usb_irq_agg_pkg::*;
#(
  parameter int NUM_EP = 8
) (
  input  logic [BUS_EVT_N-1:0] bus_evt_i,
  input  logic [NUM_EP-1:0]    ep_rx_i,
  input  logic [NUM_EP-1:0]    ep_tx_i,
  input  logic                 dma_lvl_i,
  input  logic                 wr_hit_i,
  input  logic [STAT_W-1:0]    wr_data_i,
  output logic [STAT_W-1:0]    set_o,
  output logic [STAT_W-1:0]    clr_o
);

  localparam logic [STAT_W-1:0] MASK = impl_mask(NUM_EP);

  logic [STAT_W-1:0] ep_set;
  logic [STAT_W-1:0] bus_set;

  genvar n, k;
  generate
    for (k = 0; k < BUS_EVT_N; k++) begin : g_bus
      assign bus_set[k] = bus_evt_i[k];
    end
    for (k = BUS_EVT_N; k < EP_BASE; k++) begin : g_gap
      if (k == DMA_POS) begin : g_dma
        assign bus_set[k] = dma_lvl_i;
      end else begin : g_rsv
        assign bus_set[k] = 1'b0;
      end
    end
    for (k = EP_BASE; k < STAT_W; k++) begin : g_hi
      assign bus_set[k] = 1'b0;
    end

    for (k = 0; k < EP_BASE; k++) begin : g_ep_lo
      assign ep_set[k] = 1'b0;
    end
    for (n = 0; n < MAX_EP; n++) begin : g_ep
      if (n < NUM_EP) begin : g_used
        assign ep_set[ep_rx_pos(n)] = ep_rx_i[n];
        assign ep_set[ep_tx_pos(n)] = ep_tx_i[n];
      end else begin : g_none
        assign ep_set[ep_rx_pos(n)] = 1'b0;
        assign ep_set[ep_tx_pos(n)] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    set_o = (bus_set | ep_set) & MASK;
    clr_o = wr_hit_i ? (wr_data_i & MASK) : '0;
  end

endmodule

// File: rtl/usb_irq_agg.sv
module usb_irq_agg
  import usb_irq_agg_pkg::*;
#(
  parameter int NUM_EP = 8,
  parameter int N_RSN  = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [BUS_EVT_N-1:0] bus_evt,
  input  logic [NUM_EP-1:0]    ep_rx_evt,
  input  logic [NUM_EP-1:0]    ep_tx_evt,
  input  logic [N_RSN-1:0]     dma_evt,
  input  logic                 wr_en,
  input  logic                 wr_sel,
  input  logic [STAT_W-1:0]    wr_data,
  input  logic                 rd_sel,
  output logic [STAT_W-1:0]    rd_data,
  output logic                 irq
);

  localparam logic [STAT_W-1:0] MASK = impl_mask(NUM_EP);

  initial begin
    if (NUM_EP < 1 || NUM_EP > MAX_EP) $error("NUM_EP out of range");
    if (N_RSN < 1 || N_RSN >= STAT_W) $error("N_RSN out of range");
  end

  logic [STAT_W-1:0] stat_set, stat_clr, stat_q;
  logic [N_RSN-1:0]  rsn_clr, rsn_q;
  logic              rsn_any;
  logic              stat_any;
  logic              stat_hit, rsn_hit;
  logic [STAT_W-1:0] rd_r;

  assign stat_hit = wr_en && (reg_sel_e'(wr_sel) == SEL_STATUS);
  assign rsn_hit  = wr_en && (reg_sel_e'(wr_sel) == SEL_REASON);
  assign rsn_clr  = rsn_hit ? wr_data[N_RSN-1:0] : '0;

  // DMA cause register
  usb_irq_w1c_bank #(.W(N_RSN)) u_rsn (
    .clk   (clk),
    .rst   (rst),
    .set_i (dma_evt),
    .clr_i (rsn_clr),
    .q_o   (rsn_q),
    .any_o (rsn_any)
  );

  usb_irq_src_map #(.NUM_EP(NUM_EP)) u_map (
    .bus_evt_i (bus_evt),
    .ep_rx_i   (ep_rx_evt),
    .ep_tx_i   (ep_tx_evt),
    .dma_lvl_i (rsn_any),
    .wr_hit_i  (stat_hit),
    .wr_data_i (wr_data),
    .set_o     (stat_set),
    .clr_o     (stat_clr)
  );

  usb_irq_w1c_bank #(.W(STAT_W)) u_stat (
    .clk   (clk),
    .rst   (rst),
    .set_i (stat_set),
    .clr_i (stat_clr),
    .q_o   (stat_q),
    .any_o (stat_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_r <= '0;
    end else if (reg_sel_e'(rd_sel) == SEL_REASON) begin
      rd_r <= {{(STAT_W-N_RSN){1'b0}}, rsn_q};
    end else begin
      rd_r <= stat_q;
    end
  end

  assign rd_data = rd_r;
  assign irq     = stat_any;

  // R6
  rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_q & ~MASK) == '0);

  // R9
  dma_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (rsn_q != '0) |=> stat_q[DMA_POS]);

  // R3
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (stat_q != '0));

  // R11
  rd_status_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_sel == 1'b0) |=> (rd_data == $past(stat_q)));

endmodule

// File: tb/sim_usb_irq_agg.sv
module sim_usb_irq_agg;
  localparam int CLK_P  = 10;
  localparam int NUM_EP = 8;
  localparam int N_RSN  = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [4:0]        bus_evt = '0;
  logic [NUM_EP-1:0] ep_rx_evt = '0;
  logic [NUM_EP-1:0] ep_tx_evt = '0;
  logic [N_RSN-1:0]  dma_evt = '0;
  logic              wr_en = 1'b0;
  logic              wr_sel = 1'b0;
  logic [31:0]       wr_data = '0;
  logic              rd_sel = 1'b0;
  logic [31:0]       rd_data;
  logic              irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  usb_irq_agg #(.NUM_EP(NUM_EP), .N_RSN(N_RSN)) u0 (
    .clk(clk), .rst(rst), .bus_evt(bus_evt), .ep_rx_evt(ep_rx_evt),
    .ep_tx_evt(ep_tx_evt), .dma_evt(dma_evt), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input bit sel, output logic [31:0] v);
    rd_sel = sel;
    tick();
    v = rd_data;
    rd_sel = 1'b0;
  endtask

  task automatic wr(input bit sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    tick();
    wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
  endtask

  task automatic clear_all();
    wr(1'b1, 32'hFFFF_FFFF);
    wr(1'b0, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check(irq == 1'b0, "R1", {31'b0, irq}, 32'h0);
    check(rd_data == 32'h0, "R1", rd_data, 32'h0);
    rd(1'b0, v); check(v == 32'h0, "R1", v, 32'h0);
    rd(1'b1, v); check(v == 32'h0, "R1", v, 32'h0);
  endtask

  task automatic t_bus();
    logic [31:0] v;
    for (int k = 0; k < 5; k++) begin
      bus_evt = 5'(1 << k);
      tick();
      bus_evt = '0;
      check(irq == 1'b1, "R3", {31'b0, irq}, 32'h1);
      tick(); tick();
      rd(1'b0, v);
      check(v == (32'h1 << k), "R2", v, 32'h1 << k);
      wr(1'b0, 32'h1 << k);
      check(irq == 1'b0, "R3", {31'b0, irq}, 32'h0);
    end
  endtask

  task automatic t_ep();
    logic [31:0] v, e;
    ep_rx_evt = 8'b0000_0101; ep_tx_evt = 8'b1000_0010;
    tick();
    ep_rx_evt = '0; ep_tx_evt = '0;
    e = (32'h1 << 8) | (32'h1 << 12) | (32'h1 << 11) | (32'h1 << 23);
    rd(1'b0, v);
    check(v == e, "R4", v, e);
    // R5: clear two of the four, the others stay
    wr(1'b0, (32'h1 << 12) | (32'h1 << 23));
    e = (32'h1 << 8) | (32'h1 << 11);
    rd(1'b0, v);
    check(v == e, "R5", v, e);
    check(irq == 1'b1, "R3", {31'b0, irq}, 32'h1);
    wr(1'b0, 32'h0);
    rd(1'b0, v);
    check(v == e, "R5", v, e);
    wr(1'b0, e);
    check(irq == 1'b0, "R3", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_rsv();
    logic [31:0] v;
    bus_evt = 5'h1F; ep_rx_evt = '1; ep_tx_evt = '1;
    tick();
    bus_evt = '0; ep_rx_evt = '0; ep_tx_evt = '0;
    rd(1'b0, v);
    check(v == 32'h00FF_FF1F, "R6", v, 32'h00FF_FF1F);
    wr(1'b0, 32'hFF00_00C0);
    rd(1'b0, v);
    check(v == 32'h00FF_FF1F, "R6", v, 32'h00FF_FF1F);
    clear_all();
  endtask

  task automatic t_collide();
    logic [31:0] v;
    bus_evt = 5'b00100;
    tick();
    bus_evt = 5'b00100; ep_rx_evt = 8'h02;
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = (32'h1 << 2) | (32'h1 << 10);
    tick();
    bus_evt = '0; ep_rx_evt = '0; wr_en = 1'b0; wr_data = '0;
    rd(1'b0, v);
    check(v == ((32'h1 << 2) | (32'h1 << 10)), "R7", v, (32'h1 << 2) | (32'h1 << 10));
    clear_all();
  endtask

  task automatic t_dma();
    logic [31:0] v;
    dma_evt = 4'b0100;
    tick();
    dma_evt = '0;
    check(irq == 1'b0, "R9", {31'b0, irq}, 32'h0);
    tick();
    check(irq == 1'b1, "R9", {31'b0, irq}, 32'h1);
    rd(1'b1, v);
    check(v == 32'h4, "R8", v, 32'h4);
    rd(1'b0, v);
    check(v == 32'h20, "R9", v, 32'h20);
    // clear DMA status while cause pending: no effect
    wr(1'b0, 32'h20);
    tick();
    rd(1'b0, v);
    check(v == 32'h20, "R9", v, 32'h20);
    check(irq == 1'b1, "R9", {31'b0, irq}, 32'h1);
    // reason set wins over same-cycle clear
    dma_evt = 4'b0001;
    wr_en = 1'b1; wr_sel = 1'b1; wr_data = 32'h5;
    tick();
    dma_evt = '0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
    rd(1'b1, v);
    check(v == 32'h1, "R8", v, 32'h1);
    wr(1'b1, 32'h1);
    rd(1'b1, v);
    check(v == 32'h0, "R8", v, 32'h0);
    wr(1'b0, 32'h20);
    check(irq == 1'b0, "R10", {31'b0, irq}, 32'h0);
    rd(1'b0, v);
    check(v == 32'h0, "R10", v, 32'h0);
  endtask

  task automatic t_read();
    logic [31:0] v1, v2;
    ep_tx_evt = 8'h10; dma_evt = 4'b1000;
    tick();
    ep_tx_evt = '0; dma_evt = '0;
    tick();
    rd(1'b0, v1); rd(1'b0, v2);
    check(v1 == 32'h0002_0020 && v1 == v2, "R11", v2, 32'h0002_0020);
    rd(1'b1, v1); rd(1'b1, v2);
    check(v1 == 32'h8 && v2 == 32'h8, "R11", v2, 32'h8);
    clear_all();
    check(irq == 1'b0, "R10", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_bus();
    t_ep();
    t_rsv();
    t_collide();
    t_dma();
    t_read();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule